// File: doc/BRIEF.md
# Bidirectional Reset Pin Sequencer

This block runs the reset pin of a microcontroller-style system. The pin is open-drain and shared: the block can only pull it low, while an external pull-up or some outside agent sets its level the rest of the time. An internal reset request pulls the pin low for a minimum stretch, or for longer if the request persists. The block then lets go of the pin for a short fixed window and reads it back through a synchronizer. A high reading starts reset exception processing with a one-cycle pulse. A low reading means something outside still holds reset, so the block drives the pin again for a full stretch and repeats the check.

During power-up the block keeps the pin low and the internal module reset asserted. It waits until the power-on indication drops, the PLL reports lock, and a full drive stretch of locked cycles has elapsed. The internal module reset covers every drive and release phase and falls in the same cycle as the start pulse.

Top module: `rst_pin_seq`

## Requirements
- R1: While rst_ni is low: pin_drive_o = 1, mod_rst_o = 1, start_o = 0.
- R2: In the power-up phase the pin stays driven while por_i = 1 or pll_lock_i = 0. It is released after DRIVE_CYCLES (512) clock edges with pll_lock_i = 1 and por_i = 0. Losing lock restarts that count.
- R3: A request on int_rst_req_i that lasts up to DRIVE_CYCLES cycles from the run state drives the pin (pin_drive_o = 1) for exactly DRIVE_CYCLES cycles, starting the cycle after the request is first seen.
- R4: A request lasting longer than DRIVE_CYCLES cycles keeps the pin driven until the request is removed, so the drive lasts as many cycles as the request.
- R5: Each drive phase is followed by exactly RELEASE_CYCLES (10) cycles with pin_drive_o = 0 and start_o = 0.
- R6: If the synchronized pin reads high at the end of the release window, start_o pulses high for exactly one cycle, and mod_rst_o drops in that same cycle.
- R7: If the synchronized pin reads low at the end of the release window, a new drive phase of DRIVE_CYCLES cycles begins, followed by another release window and sample. This repeats until the pin reads high.
- R8: A request that arrives during a release window aborts it and starts a fresh drive phase of DRIVE_CYCLES cycles.
- R9: mod_rst_o is high whenever pin_drive_o is high and throughout every release window. Each assertion of mod_rst_o lasts at least four cycles.
- R10: por_i = 1 in any state returns the block to the power-up phase, and the pin is driven from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Power-on indication, high while supply is not yet valid |
| pll_lock_i | input | 1 | PLL lock flag |
| int_rst_req_i | input | 1 | Internal reset request, level sensitive |
| pin_i | input | 1 | Sampled level of the reset pin (asynchronous) |
| pin_drive_o | output | 1 | Drive-enable for the pin pull-down, registered |
| mod_rst_o | output | 1 | Reset to internal modules, registered |
| start_o | output | 1 | One-cycle pulse that starts reset exception processing |

## Verification
The assertions assume that por_i, pll_lock_i and int_rst_req_i are synchronous to clk_i and only change between rising edges. Only pin_i may move at any time, because it goes through the synchronizer. The bench changes every input on the falling edge. It models the pin as a wired-AND of the block's pull-down and an outside holder, so the level read back always agrees with the drive. The minimum-length property on mod_rst_o also relies on DRIVE_CYCLES being at least four.

// File: rtl/rps_pkg.sv
package rps_pkg;
  typedef enum logic [1:0] {
    ST_PWRUP   = 2'd0,
    ST_DRIVE   = 2'd1,
    ST_RELEASE = 2'd2,
    ST_RUN     = 2'd3
  } rps_state_e;
endpackage

// File: rtl/rps_sync.sv
module rps_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rps_timer.sv
module rps_timer #(
  parameter int unsigned LIMIT = 511,
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  // saturates at LIMIT so an extended drive holds its done state
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (en_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rps_fsm.sv
module rps_fsm
  import rps_pkg::*;
#(
  parameter int unsigned DRIVE_CYCLES   = 512,
  parameter int unsigned RELEASE_CYCLES = 10,
  parameter int unsigned CNT_W          = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_i,
  input  logic             pll_lock_i,
  input  logic             int_rst_req_i,
  input  logic             pin_hi_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cnt_clr_o,
  output logic             cnt_en_o,
  output logic             pin_drive_o,
  output logic             mod_rst_o,
  output logic             start_o
);
  localparam logic [CNT_W-1:0] DRV_LAST = CNT_W'(DRIVE_CYCLES - 1);
  localparam logic [CNT_W-1:0] REL_LAST = CNT_W'(RELEASE_CYCLES - 1);

  rps_state_e state_q, state_d;
  logic drive_q, modrst_q, start_q;
  logic drv_done, rel_done, clk_ok, start_d;

  assign drv_done = (cnt_i == DRV_LAST);
  assign rel_done = (cnt_i == REL_LAST);
  assign clk_ok   = pll_lock_i && !por_i;

  always_comb begin
    state_d = state_q;
    if (por_i) state_d = ST_PWRUP;
    else begin
      unique case (state_q)
        ST_PWRUP:   if (clk_ok && drv_done) state_d = ST_RELEASE;
        ST_DRIVE:   if (drv_done && !int_rst_req_i) state_d = ST_RELEASE;
        ST_RELEASE: begin
          if (int_rst_req_i)  state_d = ST_DRIVE;
          else if (rel_done)  state_d = pin_hi_i ? ST_RUN : ST_DRIVE;
        end
        ST_RUN:     if (int_rst_req_i) state_d = ST_DRIVE;
        default:    state_d = ST_PWRUP;
      endcase
    end
  end

  assign start_d   = (state_q == ST_RELEASE) && !por_i && !int_rst_req_i
                     && rel_done && pin_hi_i;
  // counter restarts on each state entry, and in power-up whenever the clock is not good
  assign cnt_clr_o = (state_d != state_q) || ((state_q == ST_PWRUP) && !clk_ok);
  assign cnt_en_o  = (state_q == ST_DRIVE) || (state_q == ST_RELEASE)
                     || ((state_q == ST_PWRUP) && clk_ok);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q  <= ST_PWRUP;
      drive_q  <= 1'b1;
      modrst_q <= 1'b1;
      start_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      drive_q  <= (state_d == ST_PWRUP) || (state_d == ST_DRIVE);
      modrst_q <= (state_d != ST_RUN);
      start_q  <= start_d;
    end

  assign pin_drive_o = drive_q;
  assign mod_rst_o   = modrst_q;
  assign start_o     = start_q;

  p_start_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  p_start_clears_modrst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (!mod_rst_o && !pin_drive_o));
  p_start_pin_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_o) |-> $past(pin_hi_i));
  p_drive_has_modrst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_drive_o |-> mod_rst_o);
  p_modrst_min_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mod_rst_o) |-> ($past(mod_rst_o, 2) && $past(mod_rst_o, 3) && $past(mod_rst_o, 4)));
  p_req_redrives_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_rst_req_i && (state_q == ST_RELEASE || state_q == ST_RUN)) |=> (pin_drive_o && !start_o));
  p_req_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_rst_req_i && state_q == ST_DRIVE) |=> pin_drive_o);
  p_por_drives_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (pin_drive_o && mod_rst_o));
endmodule

// File: rtl/rst_pin_seq.sv
module rst_pin_seq #(
  parameter int unsigned DRIVE_CYCLES   = 512,
  parameter int unsigned RELEASE_CYCLES = 10,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_i,
  input  logic pll_lock_i,
  input  logic int_rst_req_i,
  input  logic pin_i,
  output logic pin_drive_o,
  output logic mod_rst_o,
  output logic start_o
);
  localparam int unsigned CNT_LIMIT =
    ((DRIVE_CYCLES > RELEASE_CYCLES) ? DRIVE_CYCLES : RELEASE_CYCLES) - 1;
  localparam int unsigned CNT_W = (CNT_LIMIT < 2) ? 1 : $clog2(CNT_LIMIT + 1);

  logic             pin_hi;
  logic             cnt_clr, cnt_en;
  logic [CNT_W-1:0] cnt;

  rps_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_hi)
  );

  rps_timer #(.LIMIT(CNT_LIMIT), .CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .en_i  (cnt_en),
    .cnt_o (cnt)
  );

  rps_fsm #(
    .DRIVE_CYCLES  (DRIVE_CYCLES),
    .RELEASE_CYCLES(RELEASE_CYCLES),
    .CNT_W         (CNT_W)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .por_i        (por_i),
    .pll_lock_i   (pll_lock_i),
    .int_rst_req_i(int_rst_req_i),
    .pin_hi_i     (pin_hi),
    .cnt_i        (cnt),
    .cnt_clr_o    (cnt_clr),
    .cnt_en_o     (cnt_en),
    .pin_drive_o  (pin_drive_o),
    .mod_rst_o    (mod_rst_o),
    .start_o      (start_o)
  );
endmodule

// File: tb/rst_pin_seq_test.sv
`timescale 1ns/1ps
module rst_pin_seq_test;
  localparam int DRV = 512;
  localparam int REL = 10;
  localparam int NVEC = 6;
  localparam int REQ_LEN [NVEC] = '{1, 200, 511, 512, 513, 700};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por = 1'b1, lock = 1'b0, req = 1'b0, ext_hold = 1'b0;
  logic pin, drive, modrst, start;
  int checks = 0, fails = 0;
  bit  modbad;

  always #5 clk = ~clk;
  assign pin = !(drive || ext_hold);

  rst_pin_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .por_i(por), .pll_lock_i(lock),
    .int_rst_req_i(req), .pin_i(pin),
    .pin_drive_o(drive), .mod_rst_o(modrst), .start_o(start)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic count_drive(output int n);
    n = 0;
    while (drive && n < 5000) begin
      if (!modrst) modbad = 1;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic count_release(output int n);
    n = 0;
    while (!drive && !start && n < 5000) begin
      if (!modrst) modbad = 1;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_req(input int len);
    req = 1'b1;
    fork
      begin repeat (len) @(negedge clk); req = 1'b0; end
    join_none
    @(negedge clk);
  endtask

  task automatic check_start(input string tag);
    chk(start == 1'b1, tag, start, 1);
    chk(modrst == 1'b0, "R6 mod_rst low with start", modrst, 0);
    @(negedge clk);
    chk(start == 1'b0, "R6 start one cycle", start, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n, r, exp;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(drive == 1'b1, "R1 drive", drive, 1);
    chk(modrst == 1'b1, "R1 mod_rst", modrst, 1);
    chk(start == 1'b0, "R1 start", start, 0);
    rst_n = 1'b1;
    por = 1'b0;
    repeat (50) @(negedge clk);
    chk(drive == 1'b1, "R2 held without lock", drive, 1);
    lock = 1'b1;
    modbad = 0;
    count_drive(n);
    chk(n == DRV, "R2 power-up drive", n, DRV);
    count_release(r);
    chk(r == REL, "R5 power-up release", r, REL);
    check_start("R6 start after power-up");

    // vector table: request length vs drive length
    for (int i = 0; i < NVEC; i++) begin
      exp = (REQ_LEN[i] > DRV) ? REQ_LEN[i] : DRV;
      modbad = 0;
      repeat (3) @(negedge clk);
      pulse_req(REQ_LEN[i]);
      count_drive(n);
      chk(n == exp, (REQ_LEN[i] > DRV) ? "R4 extended drive" : "R3 minimum drive", n, exp);
      count_release(r);
      chk(r == REL, "R5 release window", r, REL);
      chk(!modbad, "R9 mod_rst through drive and release", modbad, 0);
      check_start("R6 start after request");
    end

    // R7 outside holder keeps pin low through first sample
    ext_hold = 1'b1;
    modbad = 0;
    pulse_req(1);
    count_drive(n);
    chk(n == DRV, "R7 first drive", n, DRV);
    count_release(r);
    chk(r == REL, "R7 first release", r, REL);
    chk(drive == 1'b1 && start == 1'b0, "R7 redrive on low pin", drive, 1);
    repeat (100) @(negedge clk);
    ext_hold = 1'b0;
    count_drive(n);
    chk(n == DRV - 100, "R7 second drive remainder", n, DRV - 100);
    count_release(r);
    chk(r == REL, "R7 second release", r, REL);
    chk(!modbad, "R9 mod_rst through loop", modbad, 0);
    check_start("R7 start after holder lets go");

    // R8 request inside release window
    repeat (2) @(negedge clk);
    pulse_req(1);
    count_drive(n);
    repeat (3) @(negedge clk);
    chk(drive == 1'b0, "R8 in release", drive, 0);
    pulse_req(1);
    count_drive(n);
    chk(n == DRV, "R8 fresh drive", n, DRV);
    count_release(r);
    chk(r == REL, "R8 release after fresh drive", r, REL);
    check_start("R8 start");

    // R10 power-on indication from run, then lock loss (R2)
    repeat (2) @(negedge clk);
    por = 1'b1;
    lock = 1'b0;
    fork
      begin repeat (5) @(negedge clk); por = 1'b0; end
    join_none
    @(negedge clk);
    chk(drive == 1'b1 && modrst == 1'b1, "R10 por redrives", drive, 1);
    repeat (100) @(negedge clk);
    chk(drive == 1'b1, "R2 no lock keeps drive", drive, 1);
    lock = 1'b1;
    repeat (200) @(negedge clk);
    lock = 1'b0;
    @(negedge clk);
    lock = 1'b1;
    count_drive(n);
    chk(n == DRV, "R2 count restarts after lock loss", n, DRV);
    count_release(r);
    chk(r == REL, "R5 release after power-up", r, REL);
    check_start("R10 start after power-up");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule